// File: doc/BRIEF.md
# Firmware-to-OS Ownership Handoff Register

This block is a single memory-mapped control/status word that decides whether platform firmware or the operating system owns a storage host controller. Two parties hold semaphore bits in it. Firmware holds its bit from reset. The OS asks for the controller by raising its own bit and then polls until the firmware bit drops. Firmware may raise a busy flag while it finishes cleanup after it has let go. The OS waits on that flag before it touches the controller.

Software reaches the block through a simple 32-bit register port. A write strobe, an address and write data are sampled on the clock edge. Read data is combinational from the address. The firmware side has dedicated pulse inputs to release or reclaim ownership and to set or clear the busy flag. It has two outputs back to firmware: a level request that shows the OS wants the controller while firmware still holds it, and a one-cycle notification pulse for each OS ownership change. A neighbouring capability word tells software whether the handoff exists at all. When it does not, the handoff word is inert.

Top module: `own_handoff_reg`

## Requirements
- R1: After reset, with handoff support, the handoff word (offset 0x28) reads 0x00000001: bit 0 (firmware owned) is 1 and every other bit is 0.
- R2: The capability word (offset 0x24) has bit 0 equal to the SUPPORTED parameter and reads 0 in all other bits. When SUPPORTED is 0, the handoff word reads 0, writes and firmware inputs have no effect, and neither fw_own_req nor fw_notify is ever asserted.
- R3: Bit 0 (firmware owned) ignores the value software writes. A fw_release pulse clears it and a fw_claim pulse sets it.
- R4: Bit 1 (OS owned) takes the written value. fw_own_req is high exactly while bits 0 and 1 are both 1.
- R5: Bit 4 (busy) is set by fw_busy_set and cleared by fw_busy_clr, with set winning if both are asserted together. It stays set for as long as firmware holds it, and software writes to bit 4 are ignored.
- R6: Bit 2 (ownership changed) is set by any software write that changes bit 1. Writing 1 to bit 2 clears it, writing 0 leaves it unchanged, and a change of bit 1 in the same write wins over the clear.
- R7: Bit 3 (notify enable) takes the written value. fw_notify pulses high for one cycle, in the cycle after a write that changes bit 1, when that same write leaves bit 3 at 1. It does not pulse otherwise.
- R8: Bits 31:5 of the handoff word read 0. Addresses other than 0x24 and 0x28 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | ADDR_W (8) | Software byte address |
| sw_wdata | input | DATA_W (32) | Software write data |
| sw_rdata | output | DATA_W (32) | Read data for sw_addr (combinational) |
| fw_release | input | 1 | Firmware gives up ownership (clears bit 0) |
| fw_claim | input | 1 | Firmware takes ownership (sets bit 0) |
| fw_busy_set | input | 1 | Firmware raises the busy flag |
| fw_busy_clr | input | 1 | Firmware drops the busy flag |
| fw_own_req | output | 1 | OS requests the controller while firmware owns it |
| fw_notify | output | 1 | One-cycle pulse on an OS ownership change, when enabled |

## Verification
The hardest situation to reach from the ports is the cleanup window. In it the firmware bit has already dropped while busy is still high, and the OS is polling. It only exists once a complete request, release and busy sequence has been played out. The bench runs a firmware stub thread that answers the OS request by raising busy, releasing ownership and holding busy for a configurable number of cycles. At the same time, a concurrent OS thread polls the word and counts exactly how many cycles it sees busy set. A second instance built without handoff support receives the same stimulus, so that the inert case is checked on every write.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

  // bit positions inside the handoff word; software decodes these
  localparam int HS_FWO_BIT   = 0;
  localparam int HS_OSO_BIT   = 1;
  localparam int HS_CHG_BIT   = 2;
  localparam int HS_NEN_BIT   = 3;
  localparam int HS_BUSY_BIT  = 4;
  localparam int HS_USED_BITS = 5;

  // packed so that each field lands on its bit position above
  typedef struct packed {
    logic busy;
    logic nen;
    logic chg;
    logic oso;
    logic fwo;
  } hs_state_t;

  function automatic logic [HS_USED_BITS-1:0] hs_field_word(hs_state_t s);
    return s;
  endfunction

  // change flag: a fresh toggle beats a software clear
  function automatic logic chg_next(logic cur, logic clr_req, logic toggle);
    return toggle | (cur & ~clr_req);
  endfunction

  // busy flag: set beats clear
  function automatic logic busy_next(logic cur, logic set_req, logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction

  // firmware semaphore: claim beats release
  function automatic logic fwo_next(logic cur, logic claim, logic rel);
    return claim | (cur & ~rel);
  endfunction

  function automatic logic oso_changes(logic wr, logic new_val, logic cur);
    return wr & (new_val ^ cur);
  endfunction

endpackage

// File: rtl/hs_sw_decode.sv
module hs_sw_decode #(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] HS_OFS  = 8'h28,
  parameter logic [ADDR_W-1:0] CAP_OFS = 8'h24,
  parameter bit          SUPPORTED = 1'b1
) (
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  output logic              hs_sel,
  output logic              cap_sel,
  output logic              hs_wr
);

  always_comb begin
    hs_sel  = (sw_addr == HS_OFS);
    cap_sel = (sw_addr == CAP_OFS);
    hs_wr   = sw_wr & hs_sel & SUPPORTED;
  end

endmodule

// File: rtl/hs_sem_core.sv
module hs_sem_core
  import handoff_pkg::*;
#(
  parameter bit SUPPORTED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_wr,
  input  logic wr_oso,
  input  logic fw_release,
  input  logic fw_claim,
  input  logic fw_busy_set,
  input  logic fw_busy_clr,
  output logic fwo_q,
  output logic oso_q,
  output logic busy_q,
  output logic oso_toggle
);

  logic rel_g, claim_g, bset_g, bclr_g;

  // firmware-side inputs are dead when the handoff is not implemented
  always_comb begin
    rel_g   = fw_release  & SUPPORTED;
    claim_g = fw_claim    & SUPPORTED;
    bset_g  = fw_busy_set & SUPPORTED;
    bclr_g  = fw_busy_clr & SUPPORTED;
    oso_toggle = oso_changes(hs_wr, wr_oso, oso_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwo_q  <= SUPPORTED;
      oso_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      fwo_q  <= fwo_next(fwo_q, claim_g, rel_g);
      if (hs_wr) oso_q <= wr_oso;
      busy_q <= busy_next(busy_q, bset_g, bclr_g);
    end
  end

endmodule

// File: rtl/hs_chg_notify.sv
module hs_chg_notify
  import handoff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hs_wr,
  input  logic wr_chg_clr,
  input  logic wr_nen,
  input  logic oso_toggle,
  output logic chg_q,
  output logic nen_q,
  output logic notify_q
);

  logic nen_after;
  logic clr_req;

  always_comb begin
    nen_after = hs_wr ? wr_nen : nen_q;
    clr_req   = hs_wr & wr_chg_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_q    <= 1'b0;
      nen_q    <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      chg_q    <= chg_next(chg_q, clr_req, oso_toggle);
      nen_q    <= nen_after;
      notify_q <= oso_toggle & nen_after;
    end
  end

endmodule

// File: rtl/own_handoff_reg.sv
module own_handoff_reg
  import handoff_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] HS_OFS  = 8'h28,
  parameter logic [ADDR_W-1:0] CAP_OFS = 8'h24,
  parameter bit SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  input  logic              fw_release,
  input  logic              fw_claim,
  input  logic              fw_busy_set,
  input  logic              fw_busy_clr,
  output logic              fw_own_req,
  output logic              fw_notify
);

  localparam int PAD_W = DATA_W - HS_USED_BITS;

  logic hs_sel, cap_sel, hs_wr;
  logic fwo_q, oso_q, busy_q, chg_q, nen_q, notify_q;
  logic oso_toggle;
  hs_state_t state;
  logic [DATA_W-1:0] hs_word, cap_word;
  logic unused_wbits;

  assign unused_wbits = ^sw_wdata[DATA_W-1:HS_USED_BITS] ^ sw_wdata[HS_FWO_BIT]
                      ^ sw_wdata[HS_BUSY_BIT];

  hs_sw_decode #(
    .ADDR_W(ADDR_W), .HS_OFS(HS_OFS), .CAP_OFS(CAP_OFS), .SUPPORTED(SUPPORTED)
  ) u_decode (
    .sw_wr(sw_wr), .sw_addr(sw_addr),
    .hs_sel(hs_sel), .cap_sel(cap_sel), .hs_wr(hs_wr)
  );

  hs_sem_core #(.SUPPORTED(SUPPORTED)) u_sem (
    .clk(clk), .rst_n(rst_n), .hs_wr(hs_wr),
    .wr_oso(sw_wdata[HS_OSO_BIT]),
    .fw_release(fw_release), .fw_claim(fw_claim),
    .fw_busy_set(fw_busy_set), .fw_busy_clr(fw_busy_clr),
    .fwo_q(fwo_q), .oso_q(oso_q), .busy_q(busy_q), .oso_toggle(oso_toggle)
  );

  hs_chg_notify u_chg (
    .clk(clk), .rst_n(rst_n), .hs_wr(hs_wr),
    .wr_chg_clr(sw_wdata[HS_CHG_BIT]), .wr_nen(sw_wdata[HS_NEN_BIT]),
    .oso_toggle(oso_toggle),
    .chg_q(chg_q), .nen_q(nen_q), .notify_q(notify_q)
  );

  always_comb begin
    state.busy = busy_q;
    state.nen  = nen_q;
    state.chg  = chg_q;
    state.oso  = oso_q;
    state.fwo  = fwo_q;
  end

  // variant picked by the capability parameter
  generate
    if (SUPPORTED) begin : g_live
      assign hs_word    = {{PAD_W{1'b0}}, hs_field_word(state)};
      assign fw_own_req = fwo_q & oso_q;
      assign fw_notify  = notify_q;
    end else begin : g_inert
      assign hs_word    = '0;
      assign fw_own_req = 1'b0;
      assign fw_notify  = 1'b0;
    end
  endgenerate

  assign cap_word = {{(DATA_W-1){1'b0}}, SUPPORTED};

  always_comb begin
    if (hs_sel)       sw_rdata = hs_word;
    else if (cap_sel) sw_rdata = cap_word;
    else              sw_rdata = '0;
  end

endmodule

// File: rtl/own_handoff_chk.sv
module own_handoff_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] HS_OFS = 8'h28,
  parameter bit SUPPORTED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sw_addr,
  input logic [DATA_W-1:0] sw_rdata,
  input logic              fw_release,
  input logic              fw_claim,
  input logic              fw_busy_set,
  input logic              fw_own_req,
  input logic              fw_notify,
  input logic              fwo_q,
  input logic              oso_q,
  input logic              busy_q,
  input logic              chg_q,
  input logic              nen_q
);

  assert_fwo_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwo_q) |-> $past(fw_release));

  assert_fwo_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwo_q) |-> $past(fw_claim));

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(fw_busy_set));

  assert_chg_on_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oso_q != $past(oso_q)) |-> chg_q);

  assert_notify_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fw_notify |-> ((oso_q != $past(oso_q)) && nen_q));

  assert_resv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[DATA_W-1:5] == '0);

  assert_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !SUPPORTED |-> (!fw_own_req && !fw_notify && (sw_addr != HS_OFS || sw_rdata == '0)));

endmodule

bind own_handoff_reg own_handoff_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HS_OFS(HS_OFS), .SUPPORTED(SUPPORTED)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_rdata(sw_rdata),
  .fw_release(fw_release), .fw_claim(fw_claim), .fw_busy_set(fw_busy_set),
  .fw_own_req(fw_own_req), .fw_notify(fw_notify),
  .fwo_q(fwo_q), .oso_q(oso_q), .busy_q(busy_q), .chg_q(chg_q), .nen_q(nen_q)
);

// File: tb/test_own_handoff_reg.sv
module test_own_handoff_reg;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_HOLD  = 40;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] A_HS  = 8'h28;
  localparam logic [7:0] A_CAP = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [7:0]  sw_addr = 8'h00;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, rdata_ns;
  logic fw_release = 1'b0, fw_claim = 1'b0, fw_busy_set = 1'b0, fw_busy_clr = 1'b0;
  logic fw_own_req, fw_notify, own_req_ns, notify_ns;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  own_handoff_reg i_own_handoff_reg (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .fw_release(fw_release), .fw_claim(fw_claim),
    .fw_busy_set(fw_busy_set), .fw_busy_clr(fw_busy_clr),
    .fw_own_req(fw_own_req), .fw_notify(fw_notify)
  );

  own_handoff_reg #(.SUPPORTED(1'b0)) i_own_handoff_reg_nosup (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(rdata_ns),
    .fw_release(fw_release), .fw_claim(fw_claim),
    .fw_busy_set(fw_busy_set), .fw_busy_clr(fw_busy_clr),
    .fw_own_req(own_req_ns), .fw_notify(notify_ns)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    sw_addr = a;
    #1;
    d = sw_rdata;
  endtask

  task automatic rd_ns(input logic [7:0] a, output logic [31:0] d);
    sw_addr = a;
    #1;
    d = rdata_ns;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_HS, v);     chk("R1 reset handoff word", v, 32'h1);
    rd(A_CAP, v);    chk("R2 capability word", v, 32'h1);
    rd_ns(A_CAP, v); chk("R2 capability word unsupported", v, 32'h0);
    rd_ns(A_HS, v);  chk("R2 handoff word unsupported", v, 32'h0);
    chk("R4 own_req after reset", {31'b0, fw_own_req}, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(A_HS, 32'hFFFF_FFE0);
    rd(A_HS, v); chk("R8 reserved bits read zero", v, 32'h1);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R8 unmapped address reads zero", v, 32'h0);
    rd(A_HS, v);  chk("R8 unmapped write leaves word", v, 32'h1);
    wr(A_HS, 32'h0);
    rd(A_HS, v);  chk("R3 software cannot clear bit 0", v, 32'h1);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_HS, 32'h08);
    chk("R7 no pulse without bit 1 change", {31'b0, fw_notify}, 32'h0);
    rd(A_HS, v); chk("R7 enable bit written", v, 32'h09);
  endtask

  task automatic t_handoff();
    logic [31:0] v;
    int seen;
    wr(A_HS, 32'h0A);
    chk("R7 notify pulse after request", {31'b0, fw_notify}, 32'h1);
    chk("R4 own_req raised", {31'b0, fw_own_req}, 32'h1);
    chk("R2 unsupported no notify", {31'b0, notify_ns}, 32'h0);
    chk("R2 unsupported no own_req", {31'b0, own_req_ns}, 32'h0);
    rd_ns(A_HS, v); chk("R2 unsupported ignores write", v, 32'h0);
    rd(A_HS, v); chk("R6 change bit set by request", v, 32'h0F);
    @(negedge clk);
    chk("R7 notify lasts one cycle", {31'b0, fw_notify}, 32'h0);
    // firmware stub answers the request
    fw_busy_set = 1'b1; @(negedge clk); fw_busy_set = 1'b0;
    fw_release  = 1'b1; @(negedge clk); fw_release  = 1'b0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      rd(A_HS, v);
      if (v[0] == 1'b0) break;
      @(negedge clk);
    end
    chk("R3 release clears bit 0, busy held", v, 32'h1E);
    chk("R4 own_req drops after release", {31'b0, fw_own_req}, 32'h0);
    fork
      begin
        repeat (BUSY_HOLD) @(negedge clk);
        fw_busy_clr = 1'b1; @(negedge clk); fw_busy_clr = 1'b0;
      end
      begin
        for (int i = 0; i < BUSY_HOLD + 10; i++) begin
          logic [31:0] p;
          @(negedge clk);
          rd(A_HS, p);
          if (!p[4]) break;
          seen++;
        end
      end
    join
    chk("R5 busy held for stub duration", seen, BUSY_HOLD);
    rd(A_HS, v); chk("R5 busy cleared by firmware", v, 32'h0E);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_HS, 32'h0E);
    chk("R7 no pulse on unchanged bit 1", {31'b0, fw_notify}, 32'h0);
    rd(A_HS, v); chk("R6 write one clears change bit", v, 32'h0A);
    wr(A_HS, 32'h1A);
    rd(A_HS, v); chk("R5 software write to busy ignored", v, 32'h0A);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(A_HS, 32'h0C);
    chk("R7 pulse on release by OS", {31'b0, fw_notify}, 32'h1);
    rd(A_HS, v); chk("R6 toggle wins over clear", v, 32'h0C);
    wr(A_HS, 32'h04);
    rd(A_HS, v); chk("R6 clear and disable", v, 32'h00);
    wr(A_HS, 32'h02);
    chk("R7 no pulse when disabled", {31'b0, fw_notify}, 32'h0);
    rd(A_HS, v); chk("R4 bit 1 written", v, 32'h06);
  endtask

  task automatic t_claim_busy();
    logic [31:0] v;
    fw_claim = 1'b1; @(negedge clk); fw_claim = 1'b0;
    rd(A_HS, v); chk("R3 claim sets bit 0", v, 32'h07);
    chk("R4 own_req with both bits", {31'b0, fw_own_req}, 32'h1);
    fw_busy_set = 1'b1; fw_busy_clr = 1'b1; @(negedge clk);
    fw_busy_set = 1'b0; fw_busy_clr = 1'b0;
    rd(A_HS, v); chk("R5 set wins over clear", v, 32'h17);
    fw_busy_clr = 1'b1; @(negedge clk); fw_busy_clr = 1'b0;
    rd(A_HS, v); chk("R5 clear alone", v, 32'h07);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_enable();
    t_handoff();
    t_w1c();
    t_collide();
    t_claim_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule